// File: doc/BRIEF.md
# Link power mode controller

This block steps a serial display transmitter through its four power modes: shutdown, standby, acquire and transmit. It watches three things: an enable pin, the activity of an incoming pixel clock, and the lock flag of an external clock multiplier. From these it drives the enable of that multiplier, the enables of the clock and data output drivers, a one-cycle pulse that tells the serializer to latch a fresh parallel word, and a 2-bit mode code.

All timing is counted in cycles of a free-running reference clock. Three parameters set that timing: the enable-pin filter length, the activity measurement window, and the lock wait limit. Two further parameters give the edge counts per window for "clock present" and "clock absent".

The enable pin passes a symmetric glitch filter. The pixel clock is judged by counting its rising edges over each window. The sequencer turns the output drivers on and off in a fixed order, so that the receiving side always sees a clock before it sees data, and loses the clock before it loses data.

Top module: `link_pwr_ctrl`

## Requirements
- R1: `mode` reports the operating mode with this encoding: 00 shutdown, 01 standby, 10 acquire, 11 transmit.
- R2: While `rst_n` is low, the filtered enable takes the pin level directly. After reset the controller leaves shutdown within 2 cycles if `en_pin` was high, and stays in shutdown if it was low.
- R3: A change of `en_pin` is accepted only after the pin has held its new level for more than `FILT_CYC` cycles. Pulses of `FILT_CYC`-2 cycles or less, in either direction, leave `mode` unchanged.
- R4: Once per `WIN_CYC` window the monitor counts pixel-clock rising edges. A count of at least `PRESENT_CNT` means the clock is present. A count below `ABSENT_CNT` means it is absent. Any count in between keeps the previous verdict.
- R5: `clk_out_en` and `dat_out_en` are low in every mode except transmit. `mult_en` is high only in acquire or transmit.
- R6: Standby moves to acquire when the clock is judged present. Acquire moves to transmit when `mult_lock` is high while `mult_en` is high.
- R7: On entering transmit, `clk_out_en` rises first. One cycle later `dat_out_en` rises, together with a one-cycle `word_load` pulse.
- R8: In transmit, a clock judged absent sends the controller to standby. All enables drop in the same cycle. Monitoring continues, so a restarted clock leads back to acquire.
- R9: A filtered enable-low in transmit drops `clk_out_en` first. One cycle later it drops `dat_out_en` and `mult_en`, and `mode` becomes 00 at that point.
- R10: A filtered enable-low in standby or acquire sends the controller straight to shutdown.
- R11: If acquire lasts `LOCK_CYC` cycles without lock, `mult_en` is pulsed low until the next window boundary, at most `WIN_CYC` cycles. `mode` stays 10 during the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_pin | input | 1 | Asynchronous transmitter enable pin |
| pix_clk | input | 1 | Pixel clock, sampled as data |
| mult_lock | input | 1 | Lock flag from the clock multiplier |
| mult_en | output | 1 | Clock multiplier enable |
| clk_out_en | output | 1 | Clock output driver enable |
| dat_out_en | output | 1 | Data output driver enable |
| word_load | output | 1 | One-cycle pulse: latch a fresh parallel word |
| mode | output | 2 | Operating mode code |

## Verification
A sequencer stuck in the wrong state shows at the ports in the next cycle. The mode code and the three enables decode the state directly, so any illegal combination appears at once: a driver enabled outside transmit, a multiplier enabled in standby, or data enabled before the clock.

Faults in the counters take longer to show. A wrong filter count appears as a mode change that is too early or too late, measured against the filter length. A wrong monitor threshold appears within two windows, as standby or acquire persisting at a pixel rate that should have changed the mode. A lock timer fault appears as a missing or misplaced multiplier-enable dip near the wait limit.

// File: rtl/lpc_pkg.sv
// Shared types for the link power mode controller.
// Assumes: used only by the lpc_* modules and their checker.
package lpc_pkg;

    // Internal sequencer states. Several of them share one external mode code.
    typedef enum logic [2:0] {
        ST_SHUT  = 3'd0,
        ST_STBY  = 3'd1,
        ST_ACQ   = 3'd2,
        ST_RETRY = 3'd3,
        ST_TXCLK = 3'd4,
        ST_TX    = 3'd5,
        ST_DRAIN = 3'd6
    } lpc_state_e;

    localparam logic [1:0] MODE_SHUT = 2'b00;
    localparam logic [1:0] MODE_STBY = 2'b01;
    localparam logic [1:0] MODE_ACQ  = 2'b10;
    localparam logic [1:0] MODE_TX   = 2'b11;

    // Map an internal state to the 2-bit mode code seen at the port.
    function automatic logic [1:0] mode_of(lpc_state_e s);
        case (s)
            ST_SHUT:                   return MODE_SHUT;
            ST_STBY:                   return MODE_STBY;
            ST_ACQ, ST_RETRY:          return MODE_ACQ;
            default:                   return MODE_TX;
        endcase
    endfunction

endpackage

// File: rtl/lpc_sync.sv
// Multi-stage synchronizer for one asynchronous input.
// During reset every stage loads the raw input, so the output leaves
// reset already equal to the pin level.
// Assumes: STAGES >= 2.
module lpc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] stg;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage samples the raw input.
                always_ff @(posedge clk) stg[0] <= d_i;
            end else begin : g_next
                // Later stages shift the sample along; reset preloads the pin.
                always_ff @(posedge clk)
                    if (!rst_n) stg[g] <= d_i;
                    else        stg[g] <= stg[g-1];
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/lpc_en_filter.sv
// Symmetric glitch filter for the enable pin.
// The output follows a new level only after the synchronized pin has held
// that level for FILT_CYC+1 consecutive cycles. Reset loads the pin directly,
// which bypasses the filter at power-up.
// Assumes: FILT_CYC >= 1.
module lpc_en_filter #(
    parameter int FILT_CYC    = 1250,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic en_o
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic          pin_s;
    logic [CW-1:0] run_cnt;

    lpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s)
    );

    // Count consecutive cycles that differ from the accepted level; accept on overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o    <= pin_i;
            run_cnt <= '0;
        end else if (pin_s != en_o) begin
            if (run_cnt == CW'(FILT_CYC)) begin
                en_o    <= pin_s;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end else begin
            run_cnt <= '0;
        end
    end
endmodule

// File: rtl/lpc_act_mon.sv
// Pixel-clock activity monitor.
// Counts synchronized rising edges of the pixel clock over windows of
// WIN_CYC reference cycles. At each window end it declares the clock
// present (count >= PRESENT_CNT), absent (count < ABSENT_CNT), or keeps
// its previous verdict. It also pulses tick_o for one cycle at each window end.
// The monitor is cleared while run_i is low.
// Assumes: the pixel clock is slower than half the reference clock; ABSENT_CNT <= PRESENT_CNT.
module lpc_act_mon #(
    parameter int WIN_CYC     = 1000,
    parameter int PRESENT_CNT = 24,
    parameter int ABSENT_CNT  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic pix_i,
    output logic present_o,
    output logic tick_o
);
    localparam int WW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam int EW = $clog2(WIN_CYC + 1);

    logic          pix_s;
    logic          pix_d;
    logic          rise;
    logic [WW-1:0] win_cnt;
    logic [EW-1:0] edge_cnt;

    lpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pix_i), .q_o(pix_s)
    );

    // Delay the synchronized pixel clock by one cycle for edge detection.
    always_ff @(posedge clk)
        if (!rst_n) pix_d <= 1'b0;
        else        pix_d <= pix_s;

    assign rise = pix_s & ~pix_d;

    // Window counter, edge counter and the hysteretic verdict.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            win_cnt   <= '0;
            edge_cnt  <= '0;
            present_o <= 1'b0;
            tick_o    <= 1'b0;
        end else if (win_cnt == WW'(WIN_CYC - 1)) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
            tick_o   <= 1'b1;
            if (edge_cnt >= EW'(PRESENT_CNT))     present_o <= 1'b1;
            else if (edge_cnt < EW'(ABSENT_CNT))  present_o <= 1'b0;
        end else begin
            win_cnt <= win_cnt + 1'b1;
            tick_o  <= 1'b0;
            if (rise) edge_cnt <= edge_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lpc_seq.sv
// Power mode sequencer.
// Walks shutdown, standby, acquire and transmit, with substates that order
// the output enables. In transmit the clock driver turns on one cycle before
// the data driver. On shutdown the clock driver turns off one cycle before the
// data driver and the multiplier. Acquire that runs LOCK_CYC cycles without
// lock drops the multiplier enable until the next window tick.
// Assumes: en_i is already filtered; tick_i is one cycle wide.
module lpc_seq
    import lpc_pkg::*;
#(
    parameter int LOCK_CYC = 250000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       present_i,
    input  logic       tick_i,
    input  logic       lock_i,
    output logic       mult_en_o,
    output logic       clk_en_o,
    output logic       dat_en_o,
    output logic       load_o,
    output logic [1:0] mode_o
);
    localparam int TW = $clog2(LOCK_CYC + 1);

    lpc_state_e    st, st_nx;
    logic [TW-1:0] lock_tmr;

    // Next-state choice; a disabled pin has priority over loss of the clock.
    always_comb begin
        st_nx = st;
        case (st)
            ST_SHUT:  if (en_i) st_nx = ST_STBY;
            ST_STBY:  if (!en_i) st_nx = ST_SHUT;
                      else if (present_i) st_nx = ST_ACQ;
            ST_ACQ:   if (!en_i) st_nx = ST_SHUT;
                      else if (!present_i) st_nx = ST_STBY;
                      else if (lock_i) st_nx = ST_TXCLK;
                      else if (lock_tmr == TW'(LOCK_CYC - 1)) st_nx = ST_RETRY;
            ST_RETRY: if (!en_i) st_nx = ST_SHUT;
                      else if (!present_i) st_nx = ST_STBY;
                      else if (tick_i) st_nx = ST_ACQ;
            ST_TXCLK: if (!en_i) st_nx = ST_SHUT;
                      else if (!present_i) st_nx = ST_STBY;
                      else st_nx = ST_TX;
            ST_TX:    if (!en_i) st_nx = ST_DRAIN;
                      else if (!present_i) st_nx = ST_STBY;
            ST_DRAIN: st_nx = ST_SHUT;
            default:  st_nx = ST_SHUT;
        endcase
    end

    // State register, lock wait timer and the word-load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_SHUT;
            lock_tmr <= '0;
            load_o   <= 1'b0;
        end else begin
            st       <= st_nx;
            lock_tmr <= (st == ST_ACQ && st_nx == ST_ACQ) ? lock_tmr + 1'b1 : '0;
            load_o   <= (st == ST_TXCLK && st_nx == ST_TX);
        end
    end

    assign mult_en_o = (st == ST_ACQ) || (st == ST_TXCLK) || (st == ST_TX) || (st == ST_DRAIN);
    assign clk_en_o  = (st == ST_TXCLK) || (st == ST_TX);
    assign dat_en_o  = (st == ST_TX) || (st == ST_DRAIN);
    assign mode_o    = mode_of(st);
endmodule

// File: rtl/link_pwr_ctrl.sv
// Link power mode controller top.
// Joins the enable filter, the pixel-clock activity monitor and the mode
// sequencer. All timing parameters are in reference-clock cycles. The
// monitor runs whenever the filtered enable is high.
// Assumes: clk is free-running; en_pin, pix_clk and mult_lock are asynchronous to clk.
module link_pwr_ctrl #(
    parameter int FILT_CYC    = 1250,
    parameter int WIN_CYC     = 1000,
    parameter int PRESENT_CNT = 24,
    parameter int ABSENT_CNT  = 4,
    parameter int LOCK_CYC    = 250000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_pin,
    input  logic       pix_clk,
    input  logic       mult_lock,
    output logic       mult_en,
    output logic       clk_out_en,
    output logic       dat_out_en,
    output logic       word_load,
    output logic [1:0] mode
);
    logic en_f;
    logic present;
    logic tick;
    logic lock_s;

    lpc_en_filter #(.FILT_CYC(FILT_CYC), .SYNC_STAGES(SYNC_STAGES)) u_filt (
        .clk(clk), .rst_n(rst_n), .pin_i(en_pin), .en_o(en_f)
    );

    lpc_act_mon #(
        .WIN_CYC(WIN_CYC), .PRESENT_CNT(PRESENT_CNT),
        .ABSENT_CNT(ABSENT_CNT), .SYNC_STAGES(SYNC_STAGES)
    ) u_mon (
        .clk(clk), .rst_n(rst_n), .run_i(en_f), .pix_i(pix_clk),
        .present_o(present), .tick_o(tick)
    );

    lpc_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
        .clk(clk), .rst_n(rst_n), .d_i(mult_lock), .q_o(lock_s)
    );

    lpc_seq #(.LOCK_CYC(LOCK_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .en_i(en_f), .present_i(present),
        .tick_i(tick), .lock_i(lock_s & mult_en),
        .mult_en_o(mult_en), .clk_en_o(clk_out_en), .dat_en_o(dat_out_en),
        .load_o(word_load), .mode_o(mode)
    );
endmodule

// File: rtl/lpc_checker.sv
// Port-level temporal checks for link_pwr_ctrl, attached with bind.
module lpc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       mult_lock,
    input logic       mult_en,
    input logic       clk_out_en,
    input logic       dat_out_en,
    input logic       word_load,
    input logic [1:0] mode
);
    // R5: drivers are enabled only in transmit
    a_r5_drivers_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b11) |-> (!clk_out_en && !dat_out_en));

    // R5: multiplier runs only in acquire or transmit
    a_r5_mult_mode: assert property (@(posedge clk) disable iff (!rst_n)
        mult_en |-> mode[1]);

    // R7: data turns on only after the clock has been on, with a load strobe
    a_r7_clk_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dat_out_en) |-> (clk_out_en && $past(clk_out_en) && word_load));

    // R7: the load strobe marks the first data cycle only
    a_r7_load_edge: assert property (@(posedge clk) disable iff (!rst_n)
        word_load |-> (dat_out_en && !$past(dat_out_en)));

    // R9: on the way to shutdown the clock driver was already off
    a_r9_clk_off_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dat_out_en) && mode == 2'b00) |-> !$past(clk_out_en));

    // R6: transmit is entered only after the lock flag was seen
    a_r6_lock_before_tx: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_out_en) |-> $past(mult_lock, 2));
endmodule

bind link_pwr_ctrl lpc_checker u_lpc_chk (
    .clk(clk), .rst_n(rst_n), .mult_lock(mult_lock), .mult_en(mult_en),
    .clk_out_en(clk_out_en), .dat_out_en(dat_out_en),
    .word_load(word_load), .mode(mode)
);

// File: tb/sim_link_pwr_ctrl.sv
module sim_link_pwr_ctrl;
    localparam int FILT = 20;
    localparam int WIN  = 64;
    localparam int PCNT = 8;
    localparam int ACNT = 2;
    localparam int LOCK = 500;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_pin = 1'b0;
    logic       pix_clk = 1'b0;
    logic       mult_lock = 1'b0;
    logic       mult_en, clk_out_en, dat_out_en, word_load;
    logic [1:0] mode;

    int checks = 0;
    int errors = 0;
    int half = 0;
    int pc = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    link_pwr_ctrl #(
        .FILT_CYC(FILT), .WIN_CYC(WIN), .PRESENT_CNT(PCNT),
        .ABSENT_CNT(ACNT), .LOCK_CYC(LOCK), .SYNC_STAGES(2)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .pix_clk(pix_clk),
        .mult_lock(mult_lock), .mult_en(mult_en), .clk_out_en(clk_out_en),
        .dat_out_en(dat_out_en), .word_load(word_load), .mode(mode)
    );

    // Pixel clock: toggles every `half` reference cycles; half == 0 stops it.
    always @(negedge clk) begin
        if (half == 0) begin
            pix_clk <= 1'b0;
            pc <= 0;
        end else if (pc >= half - 1) begin
            pix_clk <= ~pix_clk;
            pc <= 0;
        end else begin
            pc <= pc + 1;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Expected enables for a settled mode (R1/R5).
    function automatic logic [2:0] exp_en(input logic [1:0] m);
        case (m)
            2'b10:   return 3'b100;
            2'b11:   return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    task automatic chk_mode(input string req, input logic [1:0] m);
        chk(req, {30'd0, mode}, {30'd0, m});
        chk(req, {29'd0, mult_en, clk_out_en, dat_out_en}, {29'd0, exp_en(m)});
    endtask

    task automatic do_reset(input logic pin);
        rst_n = 1'b0;
        en_pin = pin;
        cycles(3);
        rst_n = 1'b1;
    endtask

    // Random short pulses away from the current pin level (R3).
    task automatic glitches(input logic base, input logic [1:0] m, input int n);
        for (int k = 0; k < n; k++) begin
            int len;
            len = 1 + int'($urandom % (FILT - 2));
            en_pin = ~base;
            cycles(len);
            en_pin = base;
            cycles(6);
            chk("R3 short pulse ignored", {30'd0, mode}, {30'd0, m});
        end
        cycles(FILT + 6);
        chk("R3 short pulse ignored after settle", {30'd0, mode}, {30'd0, m});
    endtask

    task automatic wait_mode(input logic [1:0] m, input int lim);
        for (int i = 0; i < lim && mode != m; i++) @(negedge clk);
    endtask

    // Lock and check the ordered turn-on (R6, R7).
    task automatic go_tx();
        wait_mode(2'b10, 4 * WIN);
        for (int i = 0; i < 2 * WIN && !mult_en; i++) @(negedge clk);
        mult_lock = 1'b1;
        for (int i = 0; i < 8 && !clk_out_en; i++) @(negedge clk);
        chk("R7 clock driver on", {31'd0, clk_out_en}, 32'd1);
        chk("R7 data still off", {31'd0, dat_out_en}, 32'd0);
        chk("R7 no load yet", {31'd0, word_load}, 32'd0);
        chk("R1 transmit code", {30'd0, mode}, 32'd3);
        cycles(1);
        chk("R7 data on one cycle later", {31'd0, dat_out_en}, 32'd1);
        chk("R7 load strobe", {31'd0, word_load}, 32'd1);
        cycles(1);
        chk("R7 load is one cycle", {31'd0, word_load}, 32'd0);
        chk_mode("R6 in transmit", 2'b11);
    endtask

    initial begin
        void'($urandom(32'd20240611));

        // Reset with pin low: shutdown and stays there.
        do_reset(1'b0);
        cycles(2);
        chk_mode("R2 reset low gives shutdown", 2'b00);
        cycles(FILT + 8);
        chk_mode("R2 stays in shutdown", 2'b00);

        // Reset with pin high: bypassed filter.
        do_reset(1'b1);
        cycles(2);
        chk_mode("R2 reset high gives standby", 2'b01);

        // Short low pulses in standby.
        glitches(1'b1, 2'b01, 6);

        // Held low: not before the filter length, then shutdown.
        en_pin = 1'b0;
        cycles(FILT - 3);
        chk("R3 not accepted early", {30'd0, mode}, 32'd1);
        cycles(11);
        chk_mode("R10 standby to shutdown", 2'b00);

        // Short high pulses in shutdown, then held high.
        glitches(1'b0, 2'b00, 6);
        en_pin = 1'b1;
        cycles(FILT - 3);
        chk("R3 rise not accepted early", {30'd0, mode}, 32'd0);
        cycles(11);
        chk_mode("R3 rise accepted", 2'b01);

        // Slow and mid-band clocks from standby.
        half = 40;
        cycles(4 * WIN);
        chk_mode("R4 slow clock is absent", 2'b01);
        half = 6;
        cycles(4 * WIN);
        chk_mode("R4 mid band keeps absent", 2'b01);

        // Fast clock: acquire.
        half = 2 + int'($urandom % 2);
        wait_mode(2'b10, 3 * WIN);
        chk_mode("R6 fast clock gives acquire", 2'b10);

        // Lock wait expiry: multiplier enable dip.
        begin
            int low;
            low = 0;
            for (int i = 0; i < LOCK + 3 * WIN && mult_en; i++) @(negedge clk);
            chk("R11 multiplier dropped", {31'd0, mult_en}, 32'd0);
            chk("R11 mode stays acquire", {30'd0, mode}, 32'd2);
            for (int i = 0; i < 2 * WIN && !mult_en; i++) begin
                @(negedge clk);
                low++;
            end
            chk("R11 dip within window", {31'd0, (low >= 1 && low <= WIN)}, 32'd1);
            chk("R11 multiplier back", {31'd0, mult_en}, 32'd1);
        end

        // Mid band after present: hysteresis keeps acquire.
        half = 6;
        cycles(3 * WIN);
        chk("R4 mid band keeps present", {30'd0, mode}, 32'd2);
        half = 2;

        go_tx();

        // Clock stops: standby, all off at once; restart returns to acquire.
        half = 0;
        mult_lock = 1'b0;
        wait_mode(2'b01, 3 * WIN);
        chk_mode("R8 clock loss gives standby", 2'b01);
        half = 3;
        wait_mode(2'b10, 3 * WIN);
        chk_mode("R8 monitor kept running", 2'b10);

        go_tx();

        // Pin low in transmit: clock off first, then the rest.
        en_pin = 1'b0;
        for (int i = 0; i < FILT + 10 && clk_out_en; i++) @(negedge clk);
        chk("R9 clock driver off", {31'd0, clk_out_en}, 32'd0);
        chk("R9 data still on", {31'd0, dat_out_en}, 32'd1);
        chk("R9 multiplier still on", {31'd0, mult_en}, 32'd1);
        cycles(1);
        chk_mode("R9 then shutdown", 2'b00);
        mult_lock = 1'b0;

        // Acquire to shutdown.
        en_pin = 1'b1;
        wait_mode(2'b10, FILT + 4 * WIN);
        chk_mode("R6 re-acquire", 2'b10);
        en_pin = 1'b0;
        cycles(FILT + 6);
        chk_mode("R10 acquire to shutdown", 2'b00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule